// File: doc/BRIEF.md
# Analog Test Bus Interface Controller

This block is the digital side of the interface between a chip's two external analog test pins and its two internal analog measurement buses. It holds a four-bit scan register with separate shift and update stages. When the register is selected it is captured, shifted and updated by the usual data-register strobes of a test access port. The current instruction arrives already decoded. On every data-register update or instruction update, the block picks one of ten switch patterns from the instruction and the control value. It then drives ten switch enables that join, isolate, clamp or drive the pins and buses.

Two coarse comparators, one on each internal bus, report whether the bus sits above a threshold. Their one-bit results are loaded into the register during capture, so they can be shifted out for reading. The instruction decoder, the test access port state machine and the analog switches are outside this block.

Top module: `atb_iface_ctrl`

## Requirements
- R1: While `trst_n` is low the shift stage and update stage read 0, the held instruction is BYPASS (code 0), `pat_id` is 0 and `sw_en` shows the P0 row, without waiting for a clock edge.
- R2: A clock edge with `dr_sel` and `capture_dr` high loads the shift stage as bit0 = `bus1_above`, bit1 = `bus2_above`, and bits 3:2 = update-stage bits 3:2.
- R3: A clock edge with `dr_sel` and `shift_dr` high (and no capture) moves the shift stage one place toward bit0, with `tdi` entering bit3. `tdo` always shows shift-stage bit0.
- R4: `pat_id` and `sw_en` change only on an edge where `ir_update` is high, or where `dr_sel` and `update_dr` are both high. An update copies the shift stage into the update stage. The pattern then uses the newest instruction and control value.
- R5: Instruction codes 0 to 4 (BYPASS, SAMPLE/PRELOAD, IDCODE, USERCODE, HIGHZ) and the unassigned codes 10 to 15 always give P0.
- R6: Under codes 5, 6 and 7 (EXTEST, CLAMP, RUNBIST), control values 0 to 7 give P0 to P7, 9 gives P8, 10 gives P9, and 8 or 11 to 15 give P0.
- R7: Under codes 8 and 9 (PROBE, INTEST), control values 0 to 3 give P0 to P3, and every other value gives P0.
- R8: `sw_en[n-1]` drives switch Sn, as follows:
  - S1 joins test pin 1 to bus 1 and is on in P2, P3 and P8.
  - S2 joins test pin 2 to bus 2 and is on in P1, P3 and P9.
  - S3 and S4 drive pin 1 high and low.
  - S5 and S6 drive pin 2 high and low.
  - In P4 to P7, pin 1 takes bit1 and pin 2 takes bit0 of (P-4).
  - S7 clamps bus 1 and is on in P0, P1, P4 to P7 and P9.
  - S8 clamps bus 2 and is on in P0, P2, P4 to P7 and P8.
  - S9 and S10 are characterization paths and are on only in P8 and P9 respectively.
- R9: Exactly one pattern is active at any time, and `pat_id` gives its index 0 to 9.
- R10: With `dr_sel` low, `capture_dr`, `shift_dr` and `update_dr` have no effect on `tdo`, `pat_id` or `sw_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| instr_code | input | 4 | Decoded current instruction code |
| ir_update | input | 1 | Instruction update strobe |
| dr_sel | input | 1 | This register is the selected data register |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| bus1_above | input | 1 | Bus 1 comparator result, 1 when above threshold |
| bus2_above | input | 1 | Bus 2 comparator result, 1 when above threshold |
| tdo | output | 1 | Serial data out, shift-stage bit0 |
| sw_en | output | 10 | Switch enables S1 (bit0) to S10 (bit9) |
| pat_id | output | 4 | Index of the active pattern |

## Verification
The bench builds the block with its default parameters: a four-bit control register, ten patterns and ten switches. At that size every pairing of the sixteen instruction codes with the sixteen control values can be loaded and its switch row compared with one computed from the pattern rules. This includes the unassigned codes and the fall-back control values. The same small size lets each capture of both comparator bits be read back serially, and lets a non-selected register be shown to leave every output untouched.

// File: rtl/atb_pkg.sv
package atb_pkg;
  localparam int CTRL_W  = 4;
  localparam int NUM_PAT = 10;
  localparam int NUM_SW  = 10;
  localparam int PAT_W   = $clog2(NUM_PAT);

  typedef enum logic [3:0] {
    INS_BYPASS  = 4'd0,
    INS_SAMPLE  = 4'd1,
    INS_IDCODE  = 4'd2,
    INS_USRCODE = 4'd3,
    INS_HIGHZ   = 4'd4,
    INS_EXTEST  = 4'd5,
    INS_CLAMP   = 4'd6,
    INS_RUNBIST = 4'd7,
    INS_PROBE   = 4'd8,
    INS_INTEST  = 4'd9
  } instr_e;

  typedef logic [PAT_W-1:0]  pat_t;
  typedef logic [NUM_SW-1:0] swrow_t;

  // Pattern choice from instruction and control value.
  function automatic pat_t pick_pattern(logic [3:0] ins, logic [CTRL_W-1:0] c);
    pat_t p;
    p = '0;
    case (ins)
      INS_EXTEST, INS_CLAMP, INS_RUNBIST: begin
        if (c < CTRL_W'(8))       p = pat_t'(c);
        else if (c == CTRL_W'(9))  p = pat_t'(8);
        else if (c == CTRL_W'(10)) p = pat_t'(9);
        else                       p = '0;
      end
      INS_PROBE, INS_INTEST: begin
        if (c < CTRL_W'(4)) p = pat_t'(c);
        else                p = '0;
      end
      default: p = '0;
    endcase
    return p;
  endfunction

  // Switch row per pattern: bit n-1 drives switch Sn.
  function automatic swrow_t pattern_switches(pat_t p);
    swrow_t r;
    case (p)
      pat_t'(0): r = 10'b0011000000;
      pat_t'(1): r = 10'b0001000010;
      pat_t'(2): r = 10'b0010000001;
      pat_t'(3): r = 10'b0000000011;
      pat_t'(4): r = 10'b0011101000;
      pat_t'(5): r = 10'b0011011000;
      pat_t'(6): r = 10'b0011100100;
      pat_t'(7): r = 10'b0011010100;
      pat_t'(8): r = 10'b0110000001;
      pat_t'(9): r = 10'b1001000010;
      default:   r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/atb_scan_cell.sv
module atb_scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic cap_d,
  input  logic sh_en,
  input  logic sh_d,
  input  logic up_en,
  output logic sh_q,
  output logic up_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_q <= 1'b0;
    else if (cap_en) sh_q <= cap_d;
    else if (sh_en)  sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     up_q <= 1'b0;
    else if (up_en) up_q <= sh_q;
  end
endmodule

// File: rtl/atb_ctrl_reg.sv
module atb_ctrl_reg #(
  parameter int CW = atb_pkg::CTRL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          cap,
  input  logic          sh,
  input  logic          up,
  input  logic          tdi,
  input  logic          bus1,
  input  logic          bus2,
  output logic [CW-1:0] sh_q,
  output logic [CW-1:0] up_q,
  output logic          tdo,
  output logic          upd_evt
);
  logic cap_evt, sh_evt;
  logic [CW-1:0] cap_d, sh_d;

  assign cap_evt = sel & cap;
  assign sh_evt  = sel & sh & ~cap;
  assign upd_evt = sel & up;
  assign tdo     = sh_q[0];

  for (genvar i = 0; i < CW; i++) begin : g_cell
    if (i == 0) begin : g_b0
      assign cap_d[i] = bus1;
    end else if (i == 1) begin : g_b1
      assign cap_d[i] = bus2;
    end else begin : g_hi
      assign cap_d[i] = up_q[i];
    end
    if (i == CW - 1) begin : g_top
      assign sh_d[i] = tdi;
    end else begin : g_mid
      assign sh_d[i] = sh_q[i+1];
    end
    atb_scan_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .cap_en(cap_evt), .cap_d(cap_d[i]),
      .sh_en(sh_evt), .sh_d(sh_d[i]),
      .up_en(upd_evt),
      .sh_q(sh_q[i]), .up_q(up_q[i])
    );
  end

  // R2
  capture_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> sh_q[1:0] == $past({bus2, bus1}));
  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_evt |=> sh_q[CW-1] == $past(tdi) && sh_q[CW-2:0] == $past(sh_q[CW-1:1]));
  // R4
  update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> up_q == $past(sh_q));
  // R10
  unselected_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(sh_q) && $stable(up_q));
endmodule

// File: rtl/atb_pattern_sel.sv
module atb_pattern_sel
  import atb_pkg::*;
#(
  parameter int CW = CTRL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    instr_code,
  input  logic          ir_update,
  input  logic          dr_upd_evt,
  input  logic [CW-1:0] sh_q,
  input  logic [CW-1:0] up_q,
  output pat_t          pat_q
);
  logic [3:0]    ins_q, ins_nx;
  logic [CW-1:0] ctrl_nx;
  logic          tick, hold_p0;

  assign ins_nx  = ir_update ? instr_code : ins_q;
  assign ctrl_nx = dr_upd_evt ? sh_q : up_q;
  assign tick    = ir_update | dr_upd_evt;
  assign hold_p0 = (ins_nx <= INS_HIGHZ) || (ins_nx > INS_INTEST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ins_q <= INS_BYPASS;
    else if (ir_update) ins_q <= instr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pat_q <= '0;
    else if (tick) pat_q <= pick_pattern(ins_nx, ctrl_nx);
  end

  // R4
  pattern_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pat_q));
  // R5
  hold_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && hold_p0 |=> pat_q == '0);
  // R9
  pattern_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_q < pat_t'(NUM_PAT));
endmodule

// File: rtl/atb_switch_map.sv
module atb_switch_map
  import atb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  pat_t   pat_q,
  output swrow_t sw
);
  logic [NUM_PAT-1:0] pat_oh;

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_dec
    assign pat_oh[p] = (pat_q == pat_t'(p));
  end

  always_comb begin
    sw = '0;
    for (int p = 0; p < NUM_PAT; p++)
      sw |= {NUM_SW{pat_oh[p]}} & pattern_switches(pat_t'(p));
  end

  // R9
  one_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pat_oh) == 1);
  // R8
  pin1_drive_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw[2] && sw[3]));
  // R8
  pin2_drive_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw[4] && sw[5]));
  // R8
  bus_clamp_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw[0] && sw[6]) && !(sw[1] && sw[7]));
endmodule

// File: rtl/atb_iface_ctrl.sv
module atb_iface_ctrl
  import atb_pkg::*;
(
  input  logic              tck,
  input  logic              trst_n,
  input  logic [3:0]        instr_code,
  input  logic              ir_update,
  input  logic              dr_sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  logic              bus1_above,
  input  logic              bus2_above,
  output logic              tdo,
  output logic [NUM_SW-1:0] sw_en,
  output logic [PAT_W-1:0]  pat_id
);
  logic [CTRL_W-1:0] sh_q, up_q;
  logic              upd_evt;
  pat_t              pat_q;

  atb_ctrl_reg #(.CW(CTRL_W)) u_reg (
    .clk(tck), .rst_n(trst_n), .sel(dr_sel),
    .cap(capture_dr), .sh(shift_dr), .up(update_dr),
    .tdi(tdi), .bus1(bus1_above), .bus2(bus2_above),
    .sh_q(sh_q), .up_q(up_q), .tdo(tdo), .upd_evt(upd_evt)
  );

  atb_pattern_sel #(.CW(CTRL_W)) u_sel (
    .clk(tck), .rst_n(trst_n), .instr_code(instr_code),
    .ir_update(ir_update), .dr_upd_evt(upd_evt),
    .sh_q(sh_q), .up_q(up_q), .pat_q(pat_q)
  );

  atb_switch_map u_map (
    .clk(tck), .rst_n(trst_n), .pat_q(pat_q), .sw(sw_en)
  );

  assign pat_id = pat_q;

  // R1
  reset_p0_chk: assert property (@(posedge tck) !trst_n |-> pat_id == '0);
endmodule

// File: tb/test_atb_iface_ctrl.sv
module test_atb_iface_ctrl;
  logic tck = 0, trst_n = 0;
  logic [3:0] instr_code = 0;
  logic ir_update = 0, dr_sel = 0, capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic tdi = 0, bus1_above = 0, bus2_above = 0;
  logic tdo;
  logic [9:0] sw_en;
  logic [3:0] pat_id;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  int cur_ins = 0, cur_ctrl = 0, cur_pat = 0;

  always #4 tck = ~tck;

  atb_iface_ctrl i_atb_iface_ctrl (
    .tck(tck), .trst_n(trst_n), .instr_code(instr_code), .ir_update(ir_update),
    .dr_sel(dr_sel), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .bus1_above(bus1_above),
    .bus2_above(bus2_above), .tdo(tdo), .sw_en(sw_en), .pat_id(pat_id)
  );

  function automatic int exp_pat(int ins, int c);
    if (ins >= 5 && ins <= 7) begin
      if (c < 8) return c;
      if (c == 9) return 8;
      if (c == 10) return 9;
      return 0;
    end
    if (ins == 8 || ins == 9) return (c < 4) ? c : 0;
    return 0;
  endfunction

  function automatic logic [9:0] exp_sw(int p);
    logic [9:0] s;
    bit drv;
    int d;
    drv = (p >= 4 && p <= 7);
    d = p - 4;
    s = '0;
    s[0] = (p == 2 || p == 3 || p == 8);
    s[1] = (p == 1 || p == 3 || p == 9);
    s[2] = drv && d[1];
    s[3] = drv && !d[1];
    s[4] = drv && d[0];
    s[5] = drv && !d[0];
    s[6] = (p <= 1) || drv || (p == 9);
    s[7] = (p == 0) || (p == 2) || drv || (p == 8);
    s[8] = (p == 8);
    s[9] = (p == 9);
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(string req);
    check(req, int'(pat_id), cur_pat);
    check({req, "/R8"}, int'(sw_en), int'(exp_sw(cur_pat)));
  endtask

  task automatic ir_load(int ins);
    @(negedge tck); instr_code = 4'(ins); ir_update = 1;
    @(negedge tck); ir_update = 0;
    cur_ins = ins; cur_pat = exp_pat(cur_ins, cur_ctrl);
  endtask

  task automatic shift_in(int c);
    for (int b = 0; b < 4; b++) begin
      @(negedge tck); dr_sel = 1; shift_dr = 1; tdi = c[b];
    end
    @(negedge tck); shift_dr = 0; dr_sel = 0;
  endtask

  task automatic dr_update(int c);
    @(negedge tck); dr_sel = 1; update_dr = 1;
    @(negedge tck); update_dr = 0; dr_sel = 0;
    cur_ctrl = c; cur_pat = exp_pat(cur_ins, cur_ctrl);
  endtask

  initial begin
    while (!done) begin
      @(posedge tck);
      cycles++;
      if (cycles > 200000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<=200000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    #1;
    // R1: reset state while trst_n low
    check("R1 pat", int'(pat_id), 0);
    check("R1 sw", int'(sw_en), int'(exp_sw(0)));
    check("R1 tdo", int'(tdo), 0);
    repeat (2) @(negedge tck);
    trst_n = 1;
    @(negedge tck);

    // R5 R6 R7 R8 R4: full sweep of instruction x control
    for (int ins = 0; ins < 16; ins++) begin
      ir_load(ins);
      check_out("R4 ir_update");
      for (int c = 0; c < 16; c++) begin
        shift_in(c);
        check_out("R4 no change on shift");
        dr_update(c);
        if (ins >= 5 && ins <= 7)      check_out("R6");
        else if (ins == 8 || ins == 9) check_out("R7");
        else                           check_out("R5");
      end
    end

    // R2 R3: capture comparator bits, keep update bits 3:2
    for (int k = 0; k < 16; k++) begin
      int cv, v;
      cv = (k * 5) & 15;
      ir_load(5);
      shift_in(cv);
      dr_update(cv);
      @(negedge tck); bus1_above = k[0]; bus2_above = k[1];
      dr_sel = 1; capture_dr = 1;
      @(negedge tck); capture_dr = 0; dr_sel = 0;
      check_out("R4 no change on capture");
      v = (cv & 12) | (k[1] << 1) | k[0];
      for (int b = 0; b < 4; b++) begin
        check("R2 R3 tdo bit", int'(tdo), (v >> b) & 1);
        @(negedge tck); dr_sel = 1; shift_dr = 1; tdi = 0;
        @(negedge tck); shift_dr = 0; dr_sel = 0;
      end
    end

    // R10: strobes without select are ignored
    ir_load(5);
    shift_in(6);
    dr_update(6);
    shift_in(4'b0001);
    @(negedge tck);
    check("R10 tdo before", int'(tdo), 1);
    @(negedge tck); dr_sel = 0; shift_dr = 1; tdi = 0;
    @(negedge tck); shift_dr = 0; capture_dr = 1; bus1_above = 0;
    @(negedge tck); capture_dr = 0; update_dr = 1;
    @(negedge tck); update_dr = 0;
    check("R10 tdo", int'(tdo), 1);
    check_out("R10");

    // R9: pat_id tracks a sequence of patterns
    for (int c = 0; c < 11; c++) begin
      shift_in(c);
      dr_update(c);
      check("R9 pat index", int'(pat_id), exp_pat(5, c));
    end

    // R1: asynchronous reset mid-run
    shift_in(7);
    dr_update(7);
    check_out("R6 pre-reset");
    #1 trst_n = 0;
    #1;
    check("R1 async pat", int'(pat_id), 0);
    check("R1 async sw", int'(sw_en), int'(exp_sw(0)));
    @(negedge tck); trst_n = 1;
    cur_ins = 0; cur_ctrl = 0; cur_pat = 0;
    dr_update(0);
    check_out("R1 cleared ctrl");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule